// File: doc/BRIEF.md
# Halt and Stop Standby Sequencer

This block moves a small processor core between three conditions: running, halted and stopped. A halt instruction strobe turns off the system clock and leaves the main oscillator running, so the timers and serial units that run from the oscillator keep working. A stop instruction strobe turns off both clocks. The block decides when each standby state ends. It tells the core where to resume: at address zero after a reset, at the instruction after the standby instruction, or at an interrupt vector. It also reports which request caused the wake.

Halt and stop use different wake conditions. Halt ends on any request whose enable bit is set, whatever the master enable says. The master enable only chooses between resuming in line and taking the vector. Stop ends only on a request whose bit is set in a separate release register, and only six of its eight bits are valid. After a stop release, the oscillator runs again at once. The system clock stays off for a parameterised settling delay, and then the core resumes in line. The block never touches ports, registers or RAM, so their contents survive either standby state.

The controller runs on the free-running oscillator clock. The clock-gate cells, the oscillator and the peripherals are outside this block.

Top module: `standby_seq`

## Requirements
- R1: In run, a one-cycle `halt_req` drops `sys_clk_en` to 0 from the next cycle while `osc_clk_en` stays 1.
- R2: In run, a one-cycle `stop_req` drops both `sys_clk_en` and `osc_clk_en` to 0 from the next cycle. If `halt_req` and `stop_req` are high in the same cycle, stop is entered.
- R3: While `rst_n` is low, from any state, the block is in run: both enables are 1, `wake` is 0 and `resume_kind` is 0 (restart at address zero).
- R4: In halt, a cycle with any request `irq[i]` whose `irq_en[i]` is 1 ends halt on the next edge. `sys_clk_en` returns to 1, `wake` pulses, and `wake_src` gives the lowest such index.
- R5: A halt wake sets `resume_kind` to 1 (next instruction) when `master_en` is 0, and to 2 (take vector) when `master_en` is 1.
- R6: In halt, requests whose `irq_en` bit is 0 do not end halt, whatever the value of `rel_mask`.
- R7: In stop, only a request `irq[i]` with `rel_mask[i]` set ends stop. Only bits 0 to 4 and bit 6 of `rel_mask` are valid. Bits 5 and 7 have no effect, and so do `irq_en` and `master_en`.
- R8: On a stop release, `osc_clk_en` returns to 1 on the next cycle. `sys_clk_en` then stays 0 for SETTLE_CYCLES cycles in total before it rises. It rises in the same cycle as a `wake` pulse with `resume_kind` 1 and `wake_src` equal to the lowest releasing index.
- R9: A stop entered while no valid release bit is set is ended only by reset.
- R10: `wake` is high for exactly one cycle per wake. `resume_kind` and `wake_src` hold their values until the next wake or reset.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Free-running oscillator clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| halt_req | input | 1 | Halt instruction strobe |
| stop_req | input | 1 | Stop instruction strobe |
| irq | input | NIRQ | Interrupt request lines, index 0 highest priority |
| irq_en | input | NIRQ | Per-request enable register |
| master_en | input | 1 | Master interrupt enable |
| rel_mask | input | NIRQ | Stop release register |
| sys_clk_en | output | 1 | System clock gate enable |
| osc_clk_en | output | 1 | Main oscillator gate enable |
| resume_kind | output | 2 | 0 restart at zero, 1 next instruction, 2 vector |
| wake_src | output | IDX_W | Index of the request that caused the last wake |
| wake | output | 1 | One-cycle wake strobe |

## Verification
The bench builds the block with eight request lines, the default valid mask 0x5F and SETTLE_CYCLES = 5. A delay of five cycles lets the bench count every settling cycle, and it can see the exact cycle in which the system clock comes back. With eight lines, the bench can set the two invalid release bits, and it can raise requests that are enabled in one mask but not the other. This shows the halt mask and the stop mask staying apart. Both halt resume kinds and priority among simultaneous requests are exercised. Reset is applied out of halt and out of a stop that has no release bit set.

// File: rtl/standby_pkg.sv
package standby_pkg;

   typedef enum logic [1:0] {
      RK_ZERO   = 2'd0,
      RK_NEXT   = 2'd1,
      RK_VECTOR = 2'd2
   } resume_kind_e;

   typedef enum logic [1:0] {
      ST_RUN    = 2'd0,
      ST_HALT   = 2'd1,
      ST_STOP   = 2'd2,
      ST_SETTLE = 2'd3
   } sb_state_e;

endpackage

// File: rtl/standby_prio_enc.sv
module standby_prio_enc #(
   parameter int N         = 8,
   parameter int W         = (N > 1) ? $clog2(N) : 1,
   parameter bit LOW_FIRST = 1'b1
) (
   input  logic [N-1:0] req,
   output logic         any,
   output logic [W-1:0] idx
);

   if (N < 2) begin : g_bad_n
      $error("standby_prio_enc: N must be at least 2");
   end

   assign any = |req;

   if (LOW_FIRST) begin : g_low
      always_comb begin
         idx = '0;
         for (int i = N - 1; i >= 0; i--) begin
            if (req[i]) idx = i[W-1:0];
         end
      end
   end else begin : g_high
      always_comb begin
         idx = '0;
         for (int i = 0; i < N; i++) begin
            if (req[i]) idx = i[W-1:0];
         end
      end
   end

endmodule

// File: rtl/standby_wake_decode.sv
module standby_wake_decode #(
   parameter int             NIRQ      = 8,
   parameter int             IDX_W     = $clog2(NIRQ),
   parameter logic [NIRQ-1:0] REL_VALID = 'h5F
) (
   input  logic [NIRQ-1:0]  irq,
   input  logic [NIRQ-1:0]  irq_en,
   input  logic [NIRQ-1:0]  rel_mask,
   output logic             halt_hit,
   output logic [IDX_W-1:0] halt_src,
   output logic             stop_hit,
   output logic [IDX_W-1:0] stop_src
);

   logic [NIRQ-1:0] halt_cand;
   logic [NIRQ-1:0] stop_cand;

   assign halt_cand = irq & irq_en;
   assign stop_cand = irq & rel_mask & REL_VALID;

   standby_prio_enc #(.N(NIRQ), .W(IDX_W), .LOW_FIRST(1'b1)) u_halt_pe (
      .req (halt_cand),
      .any (halt_hit),
      .idx (halt_src)
   );

   standby_prio_enc #(.N(NIRQ), .W(IDX_W), .LOW_FIRST(1'b1)) u_stop_pe (
      .req (stop_cand),
      .any (stop_hit),
      .idx (stop_src)
   );

endmodule

// File: rtl/standby_settle_timer.sv
module standby_settle_timer #(
   parameter int CYCLES = 16
) (
   input  logic clk,
   input  logic rst_n,
   input  logic run,
   output logic done
);

   localparam int CW = (CYCLES > 1) ? $clog2(CYCLES) : 1;

   if (CYCLES < 1) begin : g_bad_cycles
      $error("standby_settle_timer: CYCLES must be at least 1");
   end

   if (CYCLES == 1) begin : g_single
      assign done = run;
   end else begin : g_count
      localparam logic [CW-1:0] LAST = CW'(CYCLES - 1);
      logic [CW-1:0] cnt;

      always_ff @(posedge clk or negedge rst_n) begin
         if (!rst_n) begin
            cnt <= '0;
         end else if (!run) begin
            cnt <= '0;
         end else if (cnt != LAST) begin
            cnt <= cnt + 1'b1;
         end
      end

      assign done = run && (cnt == LAST);

      a_r8_count_bounded: assert property (@(posedge clk) disable iff (!rst_n)
         (run && cnt != LAST) |=> (cnt == $past(cnt) + 1'b1) || !$past(run))
         else $error("a_r8_count_bounded");
   end

endmodule

// File: rtl/standby_seq.sv
module standby_seq
   import standby_pkg::*;
#(
   parameter int              NIRQ          = 8,
   parameter int              IDX_W         = $clog2(NIRQ),
   parameter logic [NIRQ-1:0] REL_VALID     = 'h5F,
   parameter int              SETTLE_CYCLES = 16
) (
   input  logic             clk,
   input  logic             rst_n,
   input  logic             halt_req,
   input  logic             stop_req,
   input  logic [NIRQ-1:0]  irq,
   input  logic [NIRQ-1:0]  irq_en,
   input  logic             master_en,
   input  logic [NIRQ-1:0]  rel_mask,
   output logic             sys_clk_en,
   output logic             osc_clk_en,
   output logic [1:0]       resume_kind,
   output logic [IDX_W-1:0] wake_src,
   output logic             wake
);

   if (NIRQ < 2 || NIRQ > 32) begin : g_bad_nirq
      $error("standby_seq: NIRQ out of range");
   end
   if (IDX_W < $clog2(NIRQ)) begin : g_bad_idx
      $error("standby_seq: IDX_W too narrow");
   end
   if (SETTLE_CYCLES < 1) begin : g_bad_settle
      $error("standby_seq: SETTLE_CYCLES must be at least 1");
   end

   sb_state_e        state;
   resume_kind_e     kind_q;
   logic             halt_hit, stop_hit, tmr_done;
   logic [IDX_W-1:0] halt_src, stop_src;

   standby_wake_decode #(.NIRQ(NIRQ), .IDX_W(IDX_W), .REL_VALID(REL_VALID)) u_dec (
      .irq      (irq),
      .irq_en   (irq_en),
      .rel_mask (rel_mask),
      .halt_hit (halt_hit),
      .halt_src (halt_src),
      .stop_hit (stop_hit),
      .stop_src (stop_src)
   );

   standby_settle_timer #(.CYCLES(SETTLE_CYCLES)) u_tmr (
      .clk   (clk),
      .rst_n (rst_n),
      .run   (state == ST_SETTLE),
      .done  (tmr_done)
   );

   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) begin
         state    <= ST_RUN;
         kind_q   <= RK_ZERO;
         wake_src <= '0;
         wake     <= 1'b0;
      end else begin
         wake <= 1'b0;
         unique case (state)
            ST_RUN: begin
               if (stop_req)      state <= ST_STOP;
               else if (halt_req) state <= ST_HALT;
            end
            ST_HALT: begin
               if (halt_hit) begin
                  state    <= ST_RUN;
                  wake     <= 1'b1;
                  wake_src <= halt_src;
                  kind_q   <= master_en ? RK_VECTOR : RK_NEXT;
               end
            end
            ST_STOP: begin
               if (stop_hit) begin
                  state    <= ST_SETTLE;
                  wake_src <= stop_src;
               end
            end
            ST_SETTLE: begin
               if (tmr_done) begin
                  state  <= ST_RUN;
                  wake   <= 1'b1;
                  kind_q <= RK_NEXT;
               end
            end
            default: state <= ST_RUN;
         endcase
      end
   end

   assign sys_clk_en  = (state == ST_RUN);
   assign osc_clk_en  = (state != ST_STOP);
   assign resume_kind = kind_q;

   a_r1_halt_gates_sys: assert property (@(posedge clk) disable iff (!rst_n)
      (sys_clk_en && halt_req && !stop_req) |=> (!sys_clk_en && osc_clk_en))
      else $error("a_r1_halt_gates_sys");

   a_r2_stop_gates_both: assert property (@(posedge clk) disable iff (!rst_n)
      (sys_clk_en && stop_req) |=> (!sys_clk_en && !osc_clk_en))
      else $error("a_r2_stop_gates_both");

   a_r4_halt_wakes: assert property (@(posedge clk) disable iff (!rst_n)
      (state == ST_HALT && |(irq & irq_en)) |=> (wake && sys_clk_en))
      else $error("a_r4_halt_wakes");

   a_r7_stop_holds: assert property (@(posedge clk) disable iff (!rst_n)
      (state == ST_STOP && !(|(irq & rel_mask & REL_VALID))) |=> !osc_clk_en)
      else $error("a_r7_stop_holds");

   a_r8_settle_gated: assert property (@(posedge clk) disable iff (!rst_n)
      (state == ST_SETTLE && !tmr_done) |=> (!sys_clk_en && osc_clk_en))
      else $error("a_r8_settle_gated");

   a_r10_wake_pulse: assert property (@(posedge clk) disable iff (!rst_n)
      wake |=> !wake)
      else $error("a_r10_wake_pulse");

   a_r10_kind_holds: assert property (@(posedge clk) disable iff (!rst_n)
      !wake |-> $stable(resume_kind))
      else $error("a_r10_kind_holds");

endmodule

// File: tb/tb_standby_seq.sv
module tb_standby_seq;

   localparam int NIRQ   = 8;
   localparam int IDX_W  = 3;
   localparam int SETTLE = 5;

   logic             clk = 1'b0;
   logic             rst_n;
   logic             halt_req, stop_req, master_en;
   logic [NIRQ-1:0]  irq, irq_en, rel_mask;
   logic             sys_clk_en, osc_clk_en, wake;
   logic [1:0]       resume_kind;
   logic [IDX_W-1:0] wake_src;

   int n_run  = 0;
   int n_fail = 0;
   bit done   = 1'b0;

   typedef struct packed {
      logic [1:0]       kind;
      logic [IDX_W-1:0] src;
   } wake_exp_t;

   wake_exp_t exp_q[$];

   always #5 clk = ~clk;

   standby_seq #(.NIRQ(NIRQ), .IDX_W(IDX_W), .REL_VALID(8'h5F), .SETTLE_CYCLES(SETTLE)) dut (
      .clk         (clk),
      .rst_n       (rst_n),
      .halt_req    (halt_req),
      .stop_req    (stop_req),
      .irq         (irq),
      .irq_en      (irq_en),
      .master_en   (master_en),
      .rel_mask    (rel_mask),
      .sys_clk_en  (sys_clk_en),
      .osc_clk_en  (osc_clk_en),
      .resume_kind (resume_kind),
      .wake_src    (wake_src),
      .wake        (wake)
   );

   task automatic chk(input bit ok, input string req, input string what,
                      input int act, input int expv);
      n_run++;
      if (!ok) begin
         n_fail++;
         $display("FAIL %s %s: actual %0d expected %0d", req, what, act, expv);
      end
   endtask

   task automatic tick();
      @(negedge clk);
   endtask

   task automatic expect_wake(input logic [1:0] k, input logic [IDX_W-1:0] s);
      wake_exp_t e;
      e.kind = k;
      e.src  = s;
      exp_q.push_back(e);
   endtask

   task automatic chk_clocks(input string req, input bit sys_e, input bit osc_e);
      chk(sys_clk_en == sys_e, req, "sys_clk_en", sys_clk_en, sys_e);
      chk(osc_clk_en == osc_e, req, "osc_clk_en", osc_clk_en, osc_e);
   endtask

   // monitor: every wake strobe pops one expected item
   always @(negedge clk) begin
      if (rst_n && wake) begin
         if (exp_q.size() == 0) begin
            chk(1'b0, "R10", "unexpected wake", 1, 0);
         end else begin
            wake_exp_t e;
            e = exp_q.pop_front();
            chk(resume_kind == e.kind, "R5", "resume_kind at wake", resume_kind, e.kind);
            chk(wake_src == e.src, "R4", "wake_src at wake", wake_src, e.src);
         end
      end
   end

   initial begin
      repeat (20000) @(posedge clk);
      if (!done) begin
         n_fail++;
         n_run++;
         $display("FAIL watchdog: actual timeout expected completion");
         $display("[TB] %0d tests run, %0d failed", n_run, n_fail);
         $finish;
      end
   end

   initial begin
      rst_n = 1'b0; halt_req = 0; stop_req = 0; master_en = 0;
      irq = '0; irq_en = '0; rel_mask = '0;
      repeat (3) tick();
      // R3 reset state
      chk_clocks("R3", 1, 1);
      chk(resume_kind == 2'd0, "R3", "resume_kind in reset", resume_kind, 0);
      chk(wake == 1'b0, "R3", "wake in reset", wake, 0);
      rst_n = 1'b1;
      tick();

      // R1 halt entry, R6 halt ignores release register and disabled requests
      irq_en = 8'h14; rel_mask = 8'hFF; master_en = 1'b0;
      halt_req = 1'b1; tick(); halt_req = 1'b0;
      chk_clocks("R1", 0, 1);
      tick();
      chk_clocks("R1", 0, 1);
      irq = 8'h01; tick(); tick();
      chk_clocks("R6", 0, 1);
      // R4/R5 wake with IME=0, two enabled requests: lowest index wins
      irq = 8'h14; expect_wake(2'd1, 3'd2); tick(); irq = '0;
      chk_clocks("R4", 1, 1);
      chk(wake == 1'b1, "R4", "wake strobe", wake, 1);
      tick();
      chk(wake == 1'b0, "R10", "wake one cycle", wake, 0);
      chk(resume_kind == 2'd1, "R10", "resume_kind held", resume_kind, 1);
      repeat (3) tick();
      chk(resume_kind == 2'd1, "R10", "resume_kind still held", resume_kind, 1);

      // R5 halt wake with IME=1 goes to vector
      master_en = 1'b1;
      halt_req = 1'b1; tick(); halt_req = 1'b0;
      chk_clocks("R1", 0, 1);
      irq = 8'h10; expect_wake(2'd2, 3'd4); tick(); irq = '0;
      chk_clocks("R5", 1, 1);
      tick();

      // R2 stop entry, R7 invalid bits and IE do not release
      rel_mask = 8'hA2; irq_en = 8'hFF;
      stop_req = 1'b1; tick(); stop_req = 1'b0;
      chk_clocks("R2", 0, 0);
      irq = 8'hA1; repeat (4) tick();
      chk_clocks("R7", 0, 0);
      // R8 release on bit 1, settle delay
      irq = 8'h02; expect_wake(2'd1, 3'd1); tick(); irq = '0;
      chk_clocks("R8", 0, 1);
      repeat (SETTLE - 1) tick();
      chk_clocks("R8", 0, 1);
      tick();
      chk_clocks("R8", 1, 1);
      chk(resume_kind == 2'd1, "R8", "resume after stop", resume_kind, 1);
      tick();

      // R2 simultaneous halt and stop: stop wins
      halt_req = 1'b1; stop_req = 1'b1; tick(); halt_req = 1'b0; stop_req = 1'b0;
      chk_clocks("R2", 0, 0);
      // release via bit 6, with bit 0 as a lower-index simultaneous release
      rel_mask = 8'h41; irq = 8'h41; expect_wake(2'd1, 3'd0); tick(); irq = '0;
      chk_clocks("R7", 0, 1);
      repeat (SETTLE) tick();
      chk_clocks("R8", 1, 1);
      tick();

      // R9 stop with no valid release bit: only reset ends it
      rel_mask = 8'hA0; master_en = 1'b1; irq_en = 8'hFF;
      stop_req = 1'b1; tick(); stop_req = 1'b0;
      irq = 8'hFF; repeat (20) tick(); irq = '0;
      chk_clocks("R9", 0, 0);
      rst_n = 1'b0; tick();
      chk_clocks("R3", 1, 1);
      chk(resume_kind == 2'd0, "R3", "restart at zero after stop", resume_kind, 0);
      rst_n = 1'b1; tick();

      // R3 reset out of halt
      halt_req = 1'b1; tick(); halt_req = 1'b0;
      chk_clocks("R1", 0, 1);
      rst_n = 1'b0; tick();
      chk_clocks("R3", 1, 1);
      rst_n = 1'b1; tick(); tick();
      chk(wake == 1'b0, "R3", "no wake after reset", wake, 0);

      chk(exp_q.size() == 0, "R10", "expected wakes left", exp_q.size(), 0);
      done = 1'b1;
      $display("[TB] %0d tests run, %0d failed", n_run, n_fail);
      $finish;
   end

endmodule